// File: doc/BRIEF.md
# Eight-Channel Burst Bus Arbiter

This block decides which of several DMA channels owns a single shared memory bus. Every channel raises a request line when it has a burst block ready to move. The arbiter gives the bus to one channel at a time on a one-hot grant vector. It keeps that grant until the same channel pulses its own block-done line, so a burst is never split and never interleaved with another channel's traffic.

A 32-bit control word sets the behaviour. One bit is a master enable. One bit picks the selection policy while the arbiter runs: lowest index wins, or rotating order that resumes after the channel served last. A 4-bit cycle-selection field is held and read back for the surrounding logic. Data movement, address sequencing and channel triggers are outside this block. Only the request, grant and done handshakes exist here.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset the grant vector is all zero and the control word reads back as zero.
- R2: A write to the control word stores bit 0 (enable), bit 31 (policy: 0 fixed, 1 rotating) and bits 19:16 (cycle selection), visible on the read port the cycle after the write edge; every other bit reads zero whatever was written.
- R3: While the enable bit is zero and no channel holds the bus, no grant is issued, whatever the requests.
- R4: The grant vector has at most one bit set, and a new grant goes only to a channel whose request was high in the cycle before it appears.
- R5: With policy bit 0, an idle arbiter with requests pending grants the lowest-numbered requesting channel on the next clock edge.
- R6: With policy bit 1, the search starts at the channel after the one granted most recently (wrapping from 7 to 0), and just after reset it starts at channel 0.
- R7: A granted channel keeps the bus until its own done bit is high. Done bits of other channels and the fall of its request line have no effect on the grant.
- R8: The edge after the granted channel's done bit is high clears the grant. The next grant is decided from the requests in that idle cycle, so at least one idle cycle separates two blocks.
- R9: A policy change written while a grant is held leaves that grant alone and governs the next decision.
- R10: Clearing enable while a block is in progress lets that block run until its done bit; after release no further grant is issued until enable is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Stored control word |
| chan_req | input | NUM_CH | Per-channel request |
| chan_done | input | NUM_CH | Per-channel block-done pulse |
| chan_grant | output | NUM_CH | One-hot bus grant |

## Verification
A control-word write and an arbitration decision can land on the same clock edge. So can a block-done pulse and a change of enable or policy. The bench provokes these cases. It rewrites the policy and the enable while a grant is held, then releases the block with requests still pending. It checks that the grant survives the write, that the release cycle is idle, and that the following decision follows the newly written setting rather than the old one. Around these cases it sweeps all 256 request patterns under the fixed policy and a pseudo-random pattern stream under the rotating policy. The expected grant comes from a lowest-bit rule and a modelled rotation pointer.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   localparam int CFG_W      = 32;
   localparam int EN_BIT     = 0;
   localparam int POLICY_BIT = 31;
   localparam int CYC_LSB    = 16;
   localparam int CYC_W      = 4;

   localparam logic [CFG_W-1:0] CFG_MASK =
      (32'd1 << EN_BIT) |
      (32'd1 << POLICY_BIT) |
      (((32'd1 << CYC_W) - 32'd1) << CYC_LSB);

   typedef enum logic {
      POL_FIXED = 1'b0,
      POL_ROUND = 1'b1
   } policy_e;

   typedef struct packed {
      logic             enable;
      policy_e          policy;
      logic [CYC_W-1:0] cycle_sel;
   } ctrl_t;

endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
   import dma_arb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] rd_data,
   output ctrl_t            ctrl
);

   logic [CFG_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (wr_en) begin
         word_q <= wr_data & CFG_MASK;
      end
   end

   always_comb begin
      rd_data        = word_q;
      ctrl.enable    = word_q[EN_BIT];
      ctrl.policy    = policy_e'(word_q[POLICY_BIT]);
      ctrl.cycle_sel = word_q[CYC_LSB +: CYC_W];
   end

endmodule

// File: rtl/dma_arb_select.sv
module dma_arb_select #(
   parameter int NUM_CH = 8,
   parameter bit HAS_RR = 1'b1,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] req,
   input  logic              rr_mode,
   input  logic [IDX_W-1:0]  last_idx,
   output logic [NUM_CH-1:0] pick
);

   localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

   logic [NUM_CH-1:0] pick_fixed;
   logic [NUM_CH-1:0] pick_rr;

   assign pick_fixed = req & (~req + ONE);

   generate
      if (HAS_RR) begin : g_rotate
         always_comb begin
            logic             found;
            logic [IDX_W-1:0] idx;
            pick_rr = '0;
            found   = 1'b0;
            for (int k = 1; k <= NUM_CH; k++) begin
               idx = IDX_W'((int'(last_idx) + k) % NUM_CH);
               if (!found && req[idx]) begin
                  pick_rr[idx] = 1'b1;
                  found        = 1'b1;
               end
            end
         end
         assign pick = rr_mode ? pick_rr : pick_fixed;
      end else begin : g_fixed_only
         assign pick_rr = pick_fixed;
         assign pick    = pick_fixed;
      end
   endgenerate

endmodule

// File: rtl/dma_arb_hold.sv
module dma_arb_hold #(
   parameter int NUM_CH = 8,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [NUM_CH-1:0] req,
   input  logic [NUM_CH-1:0] done,
   input  logic [NUM_CH-1:0] pick,
   output logic [NUM_CH-1:0] grant,
   output logic [IDX_W-1:0]  last_idx
);

   logic [NUM_CH-1:0] grant_q, grant_d;
   logic [IDX_W-1:0]  last_q, last_d;
   logic              owner_done;
   logic              start;

   assign owner_done = |(grant_q & done);
   assign start      = (grant_q == '0) && enable && (|req);

   always_comb begin
      grant_d = grant_q;
      last_d  = last_q;
      if (grant_q != '0) begin
         if (owner_done) grant_d = '0;
      end else if (start) begin
         grant_d = pick;
         for (int i = 0; i < NUM_CH; i++) begin
            if (pick[i]) last_d = IDX_W'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
         last_q  <= IDX_W'(NUM_CH - 1);
      end else begin
         grant_q <= grant_d;
         last_q  <= last_d;
      end
   end

   assign grant    = grant_q;
   assign last_idx = last_q;

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter bit HAS_RR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [NUM_CH-1:0] chan_req,
   input  logic [NUM_CH-1:0] chan_done,
   output logic [NUM_CH-1:0] chan_grant
);

   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 2) begin : g_bad_count
         $error("dma_bus_arbiter: NUM_CH must be at least 2");
      end
      if (CFG_W != 32) begin : g_bad_word
         $error("dma_bus_arbiter: control word must be 32 bits");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [NUM_CH-1:0] pick;
   logic [IDX_W-1:0]  last_idx;

   dma_arb_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .rd_data (cfg_rdata),
      .ctrl    (ctrl)
   );

   dma_arb_select #(
      .NUM_CH (NUM_CH),
      .HAS_RR (HAS_RR)
   ) u_select (
      .req      (chan_req),
      .rr_mode  (ctrl.policy == POL_ROUND),
      .last_idx (last_idx),
      .pick     (pick)
   );

   dma_arb_hold #(
      .NUM_CH (NUM_CH)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctrl.enable),
      .req      (chan_req),
      .done     (chan_done),
      .pick     (pick),
      .grant    (chan_grant),
      .last_idx (last_idx)
   );

endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       cfg_rdata,
   input logic [NUM_CH-1:0] chan_req,
   input logic [NUM_CH-1:0] chan_done,
   input logic [NUM_CH-1:0] chan_grant
);

   logic en, rr;
   assign en = cfg_rdata[EN_BIT];
   assign rr = cfg_rdata[POLICY_BIT];

   assert_cfg_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~CFG_MASK) == '0);

   assert_off_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_grant == '0 && !en) |=> chan_grant == '0);

   assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_grant));

   assert_grant_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_grant == '0) |=> ((chan_grant & ~$past(chan_req)) == '0));

   assert_fixed_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_grant == '0 && en && !rr && chan_req != '0)
      |=> ($countones(chan_grant) == 1 &&
           ((chan_grant - 1'b1) & $past(chan_req)) == '0));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_grant != '0 && (chan_grant & chan_done) == '0)
      |=> chan_grant == $past(chan_grant));

   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((chan_grant & chan_done) != '0) |=> chan_grant == '0);

endmodule

bind dma_bus_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_rdata  (cfg_rdata),
   .chan_req   (chan_req),
   .chan_done  (chan_done),
   .chan_grant (chan_grant)
);

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;

   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [31:0]   cfg_wdata;
   logic [31:0]   cfg_rdata;
   logic [N-1:0]  req, done, grant;

   int checks  = 0;
   int errors  = 0;
   int last_ch = N - 1;

   always #4 clk = ~clk;

   dma_bus_arbiter #(.NUM_CH(N)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .chan_req   (req),
      .chan_done  (done),
      .chan_grant (grant)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int idx_of(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic [N-1:0] fixed_exp(input logic [N-1:0] r);
      logic [N-1:0] e = '0;
      for (int i = 0; i < N; i++) if (r[i]) begin e[i] = 1'b1; return e; end
      return e;
   endfunction

   function automatic logic [N-1:0] rr_exp(input logic [N-1:0] r);
      logic [N-1:0] e = '0;
      for (int k = 1; k <= N; k++) begin
         int c = (last_ch + k) % N;
         if (r[c]) begin e[c] = 1'b1; return e; end
      end
      return e;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_grant(input logic [N-1:0] e, input string tag);
      chk(32'(grant), 32'(e), tag);
      if (e != '0) last_ch = idx_of(e);
   endtask

   task automatic write_cfg(input logic [31:0] d);
      cfg_we    = 1'b1;
      cfg_wdata = d;
      step();
      cfg_we    = 1'b0;
   endtask

   task automatic one_block(input logic [N-1:0] p, input bit rr, input string tag);
      logic [N-1:0] e;
      e   = rr ? rr_exp(p) : fixed_exp(p);
      req = p;
      step();
      expect_grant(e, tag);
      if (e != '0) begin
         done = e;
         step();
         chk(32'(grant), 32'h0, "R8 release after done");
         done = '0;
      end
      req = '0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [15:0] lfsr;
      req = '0; done = '0; cfg_we = 1'b0; cfg_wdata = '0; rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk(cfg_rdata, 32'h0, "R1 control after reset");
      chk(32'(grant), 32'h0, "R1 grant after reset");

      // R3: disabled, requests ignored
      req = '1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk(32'(grant), 32'h0, "R3 disabled no grant");
      end
      req = '0;

      // R2: register fields and masking
      write_cfg(32'hFFFF_FFFF);
      chk(cfg_rdata, 32'h800F_0001, "R2 all ones masked");
      write_cfg(32'h000A_0000);
      chk(cfg_rdata, 32'h000A_0000, "R2 cycle field");
      write_cfg(32'h7FF0_FFFE);
      chk(cfg_rdata, 32'h0000_0000, "R2 other bits ignored");

      // R5/R4: fixed policy, every request pattern
      write_cfg(32'h0000_0001);
      for (int p = 0; p < 256; p++) one_block(N'(p), 1'b0, "R5 R4 fixed lowest");

      // R7: hold despite foreign done and dropped request
      req = 8'h04;
      step();
      expect_grant(8'h04, "R7 initial grant");
      req  = '0;
      done = 8'h0B;
      for (int i = 0; i < 3; i++) begin
         step();
         expect_grant(8'h04, "R7 hold against other done");
      end
      // R8: idle cycle, then decision
      done = 8'h04;
      req  = 8'h10;
      step();
      chk(32'(grant), 32'h0, "R8 idle cycle after done");
      done = '0;
      step();
      expect_grant(8'h10, "R8 decision after idle");
      done = 8'h10;
      step();
      done = '0;
      req  = '0;

      // R9: fixed -> rotating while held
      req = 8'h81;
      step();
      expect_grant(8'h01, "R9 fixed grant");
      write_cfg(32'h8000_0001);
      expect_grant(8'h01, "R9 grant kept across write");
      done = 8'h01;
      step();
      chk(32'(grant), 32'h0, "R9 release");
      done = '0;
      step();
      expect_grant(8'h80, "R9 rotating applies");
      done = 8'h80;
      step();
      done = '0;
      step();
      expect_grant(8'h01, "R6 rotation wraps");
      // R9: rotating -> fixed while held
      write_cfg(32'h0000_0001);
      done = 8'h01;
      step();
      done = '0;
      step();
      expect_grant(8'h01, "R9 fixed applies");
      done = 8'h01;
      step();
      done = '0;
      req  = '0;

      // R10: enable cleared mid block
      req = 8'h02;
      step();
      expect_grant(8'h02, "R10 grant");
      write_cfg(32'h0000_0000);
      expect_grant(8'h02, "R10 block continues");
      step();
      expect_grant(8'h02, "R10 block continues");
      done = 8'h02;
      req  = '1;
      step();
      chk(32'(grant), 32'h0, "R10 release");
      done = '0;
      for (int i = 0; i < 3; i++) begin
         step();
         chk(32'(grant), 32'h0, "R10 no grant while off");
      end
      write_cfg(32'h0000_0001);
      step();
      expect_grant(8'h01, "R3 re-enabled grant");
      done = 8'h01;
      step();
      done = '0;
      req  = '0;

      // R6: rotating sweep
      write_cfg(32'h8000_0001);
      for (int i = 0; i < 16; i++) one_block('1, 1'b1, "R6 rotate full");
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         one_block(lfsr[7:0], 1'b1, "R6 R4 rotate pattern");
      end

      summary();
   end

endmodule